// File: doc/BRIEF.md
# Ring Frame Classifier with Priority Escalation

This block watches the header bytes of a received Ethernet frame one byte at a time and decides whether the frame belongs to the device-level ring protocol. The decision rests on the 16-bit length/type word. The block finds that word after stepping over up to two VLAN tags, and each tag moves the word four bytes further into the frame. The decision is taken in the cycle after the last byte of the type word arrives.

When a ring frame is found and the global ring enable is set, the block raises the frame to the top transmit queue priority on every egress port. If the host port is among the egress ports, it also steers host delivery onto a dedicated ring DMA channel. Every other frame keeps the priority it arrived with and uses the default channel. The verdict stays on the outputs until the next frame starts, so the forwarding logic downstream can sample it at any point in the frame. Queue storage and DMA are handled by other blocks.

Top module: `ring_frame_classifier`

## Requirements
- R1: After reset, `res_vld`, `ring_hit`, `q_prio` and `chan_sel` are all zero.
- R2: A frame opens with a byte that has both `rx_sof` and `rx_vld` high, and that byte is offset 0. With no tag, the type word is offset 12 (high byte) followed by offset 13. A value of 0x80E1 there, with `ring_en` high, gives `ring_hit` = 1.
- R3: The type values 0x8100 and 0x88A8 each count as a VLAN tag. Each tag moves the type position forward by 4 bytes (to 16/17, then to 20/21). A ring type behind one or two tags is detected.
- R4: Any type value other than the ring type or a tag gives no match. A third tag at offset 20 also gives no match.
- R5: `res_vld` rises in the cycle after the byte that settles the verdict is accepted. From then until the next start byte, `res_vld`, `ring_hit`, `q_prio` and `chan_sel` stay constant, whatever bytes follow.
- R6: If the byte with `rx_end` high arrives before the type field is complete, the frame is reported as valid and not a ring frame.
- R7: `ring_en` is sampled with the deciding byte. When it is low, `ring_hit` stays 0 and the outputs show the normal classification.
- R8: On a hit, `q_prio` is all ones (7 with 3 bits). Otherwise `q_prio` equals the `prio_in` sampled with the start byte.
- R9: `chan_sel` is 1 (the ring channel) only on a hit whose `egress_mask` has bit 0 (the host port) set. Otherwise it is 0 (the default channel). The mask is sampled with the start byte.
- R10: A cycle with `rx_vld` low is ignored: it does not advance the byte offset.
- R11: A start byte in the middle of a frame drops the old parse and begins a new frame at offset 0, with `res_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_vld | input | 1 | Byte strobe |
| rx_end | input | 1 | Marks the last byte of a frame |
| rx_byte | input | 8 | Frame byte |
| ring_en | input | 1 | Global enable for ring detection |
| egress_mask | input | NUM_PORTS | Destination ports, bit 0 = host |
| prio_in | input | PRIO_W | Priority the frame arrived with |
| res_vld | output | 1 | Verdict valid |
| ring_hit | output | 1 | Frame is a ring frame |
| q_prio | output | PRIO_W | Transmit queue priority |
| chan_sel | output | CHAN_W | Host delivery channel |

## Verification
The bench builds the block with its defaults: three ports with the host at bit 0, a 3-bit priority, a 2-bit channel and a tag limit of two. With these values the deepest legal type position (offsets 20/21) is reachable, and so is the third-tag rejection one step past it. Random frames vary the tag count from zero to three, the frame length from well short of offset 12 up to past offset 21, the enable bit, the mask and the byte gaps. Directed frames cover the tag limit, runts that stop between the two type bytes, a restart in mid-frame and the hold of the verdict after decision.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [15:0] RING_TYPE  = 16'h80E1;
  localparam logic [15:0] CTAG_TYPE  = 16'h8100;
  localparam logic [15:0] STAG_TYPE  = 16'h88A8;
  localparam int          HDR_OFF    = 12;
  localparam int          TAG_LEN    = 4;

  function automatic logic is_vlan_tag(input logic [15:0] w);
    return (w == CTAG_TYPE) || (w == STAG_TYPE);
  endfunction

  typedef struct packed {
    logic decide;
    logic ring;
  } verdict_t;
endpackage

// File: rtl/rfc_offset_track.sv
module rfc_offset_track #(
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_vld,
  input  logic             stop_i,
  output logic [OFF_W-1:0] cur_off,
  output logic             active
);
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [OFF_W-1:0] off_q, off_d;
  logic             act_q, act_d;

  // the start byte is offset 0 and opens a frame
  always_comb begin
    cur_off = rx_sof ? '0 : off_q;
    active  = rx_sof | act_q;
  end

  always_comb begin
    off_d = off_q;
    act_d = act_q;
    if (rx_vld) begin
      off_d = (cur_off == OFF_MAX) ? OFF_MAX : cur_off + 1'b1;
      if (rx_sof) act_d = 1'b1;
      if (stop_i) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      act_q <= 1'b0;
    end else begin
      off_q <= off_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/rfc_type_match.sv
module rfc_type_match
  import rfc_pkg::*;
#(
  parameter int MAX_TAGS = 2,
  parameter int OFF_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_vld,
  input  logic             rx_end,
  input  logic             active,
  input  logic [OFF_W-1:0] cur_off,
  input  logic [7:0]       rx_byte,
  output verdict_t         verdict
);
  localparam int TAG_W = $clog2(MAX_TAGS + 2);

  logic [TAG_W-1:0] tags_q, tags_d;
  logic [7:0]       hi_q, hi_d;
  logic [OFF_W-1:0] type_pos;
  logic [15:0]      word;
  logic             acc;

  always_comb begin
    type_pos = OFF_W'(HDR_OFF + TAG_LEN * int'(tags_q));
    acc      = rx_vld & active;
    word     = {hi_q, rx_byte};
  end

  // the decision is taken on the low byte of the type word, or on an early end
  always_comb begin
    tags_d  = tags_q;
    hi_d    = hi_q;
    verdict = '0;
    if (acc && cur_off == type_pos) begin
      hi_d = rx_byte;
      if (rx_end) verdict.decide = 1'b1;
    end else if (acc && cur_off == type_pos + 1'b1) begin
      if (word == RING_TYPE) begin
        verdict.decide = 1'b1;
        verdict.ring   = 1'b1;
      end else if (is_vlan_tag(word) && int'(tags_q) < MAX_TAGS && !rx_end) begin
        tags_d = tags_q + 1'b1;
      end else begin
        verdict.decide = 1'b1;
      end
    end else if (acc && rx_end) begin
      verdict.decide = 1'b1;
    end
    if (rx_sof && rx_vld) tags_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags_q <= '0;
      hi_q   <= '0;
    end else begin
      tags_q <= tags_d;
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/rfc_verdict.sv
module rfc_verdict
  import rfc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int HOST_PORT = 0,
  parameter int PRIO_W    = 3,
  parameter int CHAN_W    = 2,
  parameter int RING_CHAN = 1,
  parameter int NORM_CHAN = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_acc,
  input  verdict_t             verdict,
  input  logic                 ring_en,
  input  logic [NUM_PORTS-1:0] egress_mask,
  input  logic [PRIO_W-1:0]    prio_in,
  output logic                 res_vld,
  output logic                 ring_hit,
  output logic [PRIO_W-1:0]    q_prio,
  output logic [CHAN_W-1:0]    chan_sel
);
  logic                 vld_q, vld_d;
  logic                 hit_q, hit_d;
  logic [PRIO_W-1:0]    prio_q, prio_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic                 host_egress;

  generate
    if (HOST_PORT >= 0 && HOST_PORT < NUM_PORTS) begin : g_host
      assign host_egress = mask_q[HOST_PORT];
    end else begin : g_nohost
      assign host_egress = 1'b0;
    end
  endgenerate

  always_comb begin
    vld_d  = vld_q;
    hit_d  = hit_q;
    prio_d = prio_q;
    mask_d = mask_q;
    if (start_acc) begin
      vld_d  = 1'b0;
      hit_d  = 1'b0;
      prio_d = prio_in;
      mask_d = egress_mask;
    end
    if (verdict.decide) begin
      vld_d = 1'b1;
      hit_d = verdict.ring & ring_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      prio_q <= '0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hit_q  <= hit_d;
      prio_q <= prio_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    res_vld  = vld_q;
    ring_hit = hit_q;
    q_prio   = hit_q ? {PRIO_W{1'b1}} : prio_q;
    chan_sel = (hit_q && host_egress) ? CHAN_W'(RING_CHAN) : CHAN_W'(NORM_CHAN);
  end
endmodule

// File: rtl/ring_frame_classifier.sv
module ring_frame_classifier
  import rfc_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int HOST_PORT = 0,
  parameter int PRIO_W    = 3,
  parameter int CHAN_W    = 2,
  parameter int RING_CHAN = 1,
  parameter int NORM_CHAN = 0,
  parameter int MAX_TAGS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_sof,
  input  logic                 rx_vld,
  input  logic                 rx_end,
  input  logic [7:0]           rx_byte,
  input  logic                 ring_en,
  input  logic [NUM_PORTS-1:0] egress_mask,
  input  logic [PRIO_W-1:0]    prio_in,
  output logic                 res_vld,
  output logic                 ring_hit,
  output logic [PRIO_W-1:0]    q_prio,
  output logic [CHAN_W-1:0]    chan_sel
);
  localparam int LAST_OFF = HDR_OFF + TAG_LEN * MAX_TAGS + 1;
  localparam int OFF_W    = $clog2(LAST_OFF + 1) + 1;

  logic [OFF_W-1:0] cur_off;
  logic             active;
  verdict_t         verdict;
  logic             start_acc;

  assign start_acc = rx_sof & rx_vld;

  rfc_offset_track #(.OFF_W(OFF_W)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_sof  (rx_sof),
    .rx_vld  (rx_vld),
    .stop_i  (verdict.decide),
    .cur_off (cur_off),
    .active  (active)
  );

  rfc_type_match #(.MAX_TAGS(MAX_TAGS), .OFF_W(OFF_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_sof  (rx_sof),
    .rx_vld  (rx_vld),
    .rx_end  (rx_end),
    .active  (active),
    .cur_off (cur_off),
    .rx_byte (rx_byte),
    .verdict (verdict)
  );

  rfc_verdict #(
    .NUM_PORTS (NUM_PORTS),
    .HOST_PORT (HOST_PORT),
    .PRIO_W    (PRIO_W),
    .CHAN_W    (CHAN_W),
    .RING_CHAN (RING_CHAN),
    .NORM_CHAN (NORM_CHAN)
  ) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_acc   (start_acc),
    .verdict     (verdict),
    .ring_en     (ring_en),
    .egress_mask (egress_mask),
    .prio_in     (prio_in),
    .res_vld     (res_vld),
    .ring_hit    (ring_hit),
    .q_prio      (q_prio),
    .chan_sel    (chan_sel)
  );
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int PRIO_W    = 3,
  parameter int CHAN_W    = 2,
  parameter int NORM_CHAN = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_sof,
  input logic              rx_vld,
  input logic              ring_en,
  input logic              res_vld,
  input logic              ring_hit,
  input logic [PRIO_W-1:0] q_prio,
  input logic [CHAN_W-1:0] chan_sel
);
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && rx_vld) |=> !res_vld);

  a_r5_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !(rx_sof && rx_vld)) |=>
      (res_vld && $stable(ring_hit) && $stable(q_prio) && $stable(chan_sel)));

  a_r8_hit_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
    ring_hit |-> (q_prio == {PRIO_W{1'b1}}));

  a_r9_ring_chan_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != CHAN_W'(NORM_CHAN)) |-> ring_hit);

  a_r7_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_vld && !(rx_sof && rx_vld) && !ring_en) |=> !ring_hit);

  a_r5_hit_only_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ring_hit |-> res_vld);
endmodule

bind ring_frame_classifier rfc_checker #(
  .PRIO_W    (PRIO_W),
  .CHAN_W    (CHAN_W),
  .NORM_CHAN (NORM_CHAN)
) u_rfc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_sof   (rx_sof),
  .rx_vld   (rx_vld),
  .ring_en  (ring_en),
  .res_vld  (res_vld),
  .ring_hit (ring_hit),
  .q_prio   (q_prio),
  .chan_sel (chan_sel)
);

// File: tb/tb_ring_frame_classifier.sv
`timescale 1ns/1ps
module tb_ring_frame_classifier;
  localparam int NP = 3;
  localparam int PW = 3;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_sof, rx_vld, rx_end, ring_en;
  logic [7:0]    rx_byte;
  logic [NP-1:0] egress_mask;
  logic [PW-1:0] prio_in;
  logic          res_vld, ring_hit;
  logic [PW-1:0] q_prio;
  logic [CW-1:0] chan_sel;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [7:0] fb [0:47];
  int   gap_pct = 0;

  always #2 clk = ~clk;

  ring_frame_classifier dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_end(rx_end),
    .rx_byte(rx_byte), .ring_en(ring_en), .egress_mask(egress_mask), .prio_in(prio_in),
    .res_vld(res_vld), .ring_hit(ring_hit), .q_prio(q_prio), .chan_sel(chan_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference: returns 1 when the header holds a ring type behind at most two tags
  function automatic bit ring_model(input int len);
    int pos = 12;
    for (int t = 0; t < 3; t++) begin
      logic [15:0] w;
      if (len < pos + 2) return 0;
      w = {fb[pos], fb[pos+1]};
      if (w == 16'h80E1) return 1;
      if ((w == 16'h8100 || w == 16'h88A8) && t < 2) pos += 4;
      else return 0;
    end
    return 0;
  endfunction

  task automatic idle();
    @(negedge clk);
    rx_vld = 0; rx_sof = 0; rx_end = 0;
  endtask

  task automatic put(input logic [7:0] b, input bit s, input bit e);
    while (gap_pct > 0 && ($urandom % 100) < gap_pct) idle();
    @(negedge clk);
    rx_byte = b; rx_vld = 1; rx_sof = s; rx_end = e;
  endtask

  task automatic send(input int len, input bit en, input logic [NP-1:0] m, input logic [PW-1:0] p);
    ring_en = en; egress_mask = m; prio_in = p;
    for (int i = 0; i < len; i++) put(fb[i], i == 0, i == len - 1);
    idle();
  endtask

  task automatic verify(input string tag, input int len, input bit en,
                        input logic [NP-1:0] m, input logic [PW-1:0] p);
    bit h = ring_model(len) & en;
    check({tag, " R5 res_vld"}, res_vld, 1);
    check({tag, " R2/R3/R4/R7 ring_hit"}, ring_hit, h);
    check({tag, " R8 q_prio"}, q_prio, h ? 7 : p);
    check({tag, " R9 chan_sel"}, chan_sel, (h && m[0]) ? 1 : 0);
  endtask

  task automatic build(input int ntags, input bit ring);
    for (int i = 0; i < 48; i++) fb[i] = 8'($urandom);
    for (int t = 0; t < ntags; t++) begin
      fb[12+4*t]   = 8'h81 ^ (t[0] ? 8'h09 : 8'h00);
      fb[12+4*t+1] = t[0] ? 8'hA8 : 8'h00;
    end
    fb[12+4*ntags]   = ring ? 8'h80 : 8'h08;
    fb[12+4*ntags+1] = ring ? 8'hE1 : 8'h00;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; rx_sof = 0; rx_vld = 0; rx_end = 0; rx_byte = 0;
    ring_en = 0; egress_mask = 0; prio_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 res_vld", res_vld, 0);
    check("R1 ring_hit", ring_hit, 0);
    check("R1 q_prio", q_prio, 0);
    check("R1 chan_sel", chan_sel, 0);

    // R2 untagged ring, host egress
    build(0, 1); send(20, 1, 3'b011, 3'd2); verify("R2 untagged", 20, 1, 3'b011, 3'd2);
    check("R9 ring channel", chan_sel, 1);
    // R3 one tag, no host
    build(1, 1); send(24, 1, 3'b110, 3'd1); verify("R3 one tag", 24, 1, 3'b110, 3'd1);
    check("R3 hit after one tag", ring_hit, 1);
    // R3 two tags
    build(2, 1); send(30, 1, 3'b001, 3'd0); verify("R3 two tags", 30, 1, 3'b001, 3'd0);
    check("R3 hit after two tags", ring_hit, 1);
    // R4 three tags then ring
    build(3, 1); send(34, 1, 3'b111, 3'd4); verify("R4 three tags", 34, 1, 3'b111, 3'd4);
    check("R4 third tag no hit", ring_hit, 0);
    // R7 enable off
    build(0, 1); send(20, 0, 3'b111, 3'd3); verify("R7 disabled", 20, 0, 3'b111, 3'd3);
    check("R7 no hit", ring_hit, 0);
    // R6 runt ending between type bytes
    build(0, 1); send(13, 1, 3'b111, 3'd5); verify("R6 runt", 13, 1, 3'b111, 3'd5);
    check("R6 runt no hit", ring_hit, 0);

    // R5 hold: ring type repeated later in the frame does not change a miss
    build(0, 0); fb[18] = 8'h80; fb[19] = 8'hE1;
    send(26, 1, 3'b001, 3'd6);
    repeat (5) idle();
    check("R5 held miss", ring_hit, 0);
    check("R5 held prio", q_prio, 6);
    check("R5 held valid", res_vld, 1);

    // R11 restart mid-frame, then R11 res_vld low after new start byte
    build(0, 1); ring_en = 1; egress_mask = 3'b001; prio_in = 3'd1;
    for (int i = 0; i < 8; i++) put(fb[i], i == 0, 0);
    idle();
    check("R11 not valid mid-frame", res_vld, 0);
    for (int i = 0; i < 8; i++) put(8'h55, 0, 0);
    build(1, 1); send(22, 1, 3'b001, 3'd1); verify("R11 restart", 22, 1, 3'b001, 3'd1);

    // R10 random frames with idle gaps
    gap_pct = 25;
    for (int k = 0; k < 300; k++) begin
      int nt = $urandom % 4;
      int len = 6 + ($urandom % 30);
      bit en = ($urandom % 4) != 0;
      logic [NP-1:0] m = NP'($urandom);
      logic [PW-1:0] p = PW'($urandom);
      build(nt, ($urandom % 2) == 1);
      send(len, en, m, p);
      verify("R10 random", len, en, m, p);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule